// File: doc/BRIEF.md
# Self-Timed Dual-Rail 4x4 Unsigned Multiplier

This block multiplies two unsigned 4-bit operands without any clock. Every bit travels on two wires. A four-phase handshake separates each operand pair from the next by a neutral "spacer" wave. Partial products come from dual-rail AND cells. A ripple array of twelve dual-rail adder cells reduces them, and each adder is built from minterm state-holding (Muller) gates. A completion detector watches the 8-bit product and raises `ack` once every bit has resolved. It drops `ack` once every bit has gone back to spacer.

A parameter fixes the spacer polarity at elaboration. In return-to-zero mode the spacer has both wires low. In return-to-one mode the spacer has both wires high, and every data code is the inverse of its return-to-zero code. The environment waits for `ack` to rise before it withdraws the operands, and waits for `ack` to fall before it presents the next pair. A low `rst_n` clears every state-holding gate to its spacer value.

Top module: `dr_array_mult`

## Requirements
- R1: Once `ack` is high, the product rails carry the exact unsigned product a*b of the two 4-bit operands, with bit k of the product on output index k.
- R2: With RTO=0, a spacer bit is (one,zero)=(0,0). A bit of value 1 is (1,0) and a bit of value 0 is (0,1). This encoding applies to operands and product alike.
- R3: With RTO=1, a spacer bit is (one,zero)=(1,1). A bit of value 1 is (0,1) and a bit of value 0 is (1,0). This encoding applies to operands and product alike.
- R4: No product bit ever shows the illegal pair. The illegal pair is (1,1) with RTO=0 and (0,0) with RTO=1.
- R5: `ack` rises only when all 8 product bits hold valid codes.
- R6: `ack` falls only when all 8 product bits are spacer.
- R7: While one operand is valid and the other is still spacer, every product bit stays spacer and `ack` stays low.
- R8: After `ack` has risen, returning only one operand to spacer leaves the product valid and unchanged, and `ack` stays high.
- R9: While `rst_n` is low, every product bit is spacer and `ack` is low.
- R10: The RTO parameter alone selects the protocol. A WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset of all state-holding gates |
| a_one | input | 4 | Operand A, true rail of each bit |
| a_zero | input | 4 | Operand A, false rail of each bit |
| b_one | input | 4 | Operand B, true rail of each bit |
| b_zero | input | 4 | Operand B, false rail of each bit |
| p_one | output | 8 | Product, true rail of each bit |
| p_zero | output | 8 | Product, false rail of each bit |
| ack | output | 1 | Completion: high when all product bits are valid, low when all are spacer |

## Verification
The bench runs every operand pair through a return-to-zero instance and a return-to-one instance at the same time. A wrong minterm or carry mapping therefore shows up as a product mismatch in one mode or both. A wrong inversion shows up as a mismatch in return-to-one mode only. Two targeted sequences go after indication faults. The first holds one operand in spacer. A cell that fires early would raise `ack` or leak a valid bit. The second withdraws a single operand after completion. A gate that releases early would drop `ack` or corrupt the product. Each cycle also checks that the product is fully spacer once `ack` has fallen. A detector with the wrong gate type or the wrong polarity would report completion too soon or never.

// File: rtl/drm_pkg.sv
package drm_pkg;

   // one dual-rail bit: exactly one rail high is data, both low is spacer (internal sense)
   typedef struct packed {
      logic one;
      logic zero;
   } drail_t;

   function automatic int unsigned pop_cnt(input int unsigned v);
      int unsigned n;
      n = 0;
      for (int unsigned k = 0; k < 32; k++) n += (v >> k) & 1;
      return n;
   endfunction

endpackage

// File: rtl/drm_celem.sv
module drm_celem #(
   parameter int unsigned N_IN    = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic            rst_n,
   input  logic [N_IN-1:0] in_i,
   output logic            q_o
);

   if (N_IN < 1) begin : g_bad_n
      $error("drm_celem: N_IN must be at least 1");
   end

   // state-holding gate: set on all ones, clear on all zeros, otherwise hold
   always_latch begin
      if (!rst_n)               q_o <= RST_VAL;
      else if (&in_i)           q_o <= 1'b1;
      else if (!(|in_i))        q_o <= 1'b0;
   end

endmodule

// File: rtl/drm_and2.sv
module drm_and2
   import drm_pkg::*;
(
   input  logic   rst_n,
   input  drail_t a_i,
   input  drail_t b_i,
   output drail_t y_o
);

   logic [3:0] mt;

   for (genvar m = 0; m < 4; m++) begin : g_mt
      localparam bit SEL_A = ((m >> 1) & 1) != 0;
      localparam bit SEL_B = (m & 1) != 0;
      logic ra, rb;
      assign ra = SEL_A ? a_i.one : a_i.zero;
      assign rb = SEL_B ? b_i.one : b_i.zero;
      drm_celem #(.N_IN(2), .RST_VAL(1'b0)) u_c (
         .rst_n (rst_n),
         .in_i  ({ra, rb}),
         .q_o   (mt[m])
      );
   end

   logic y1, y0;
   assign y1 = mt[3];
   assign y0 = |mt[2:0];
   assign y_o.one  = y1;
   assign y_o.zero = y0;

   // R7
   always @(posedge y1 or posedge y0)
      if (rst_n === 1'b1)
         and_fire_chk: assert ((a_i.one ^ a_i.zero) && (b_i.one ^ b_i.zero));

   // R8
   always @(negedge y1 or negedge y0)
      if (rst_n === 1'b1)
         and_release_chk: assert (!(a_i.one | a_i.zero | b_i.one | b_i.zero));

endmodule

// File: rtl/drm_adder.sv
module drm_adder
   import drm_pkg::*;
#(
   parameter int unsigned N_IN = 3
) (
   input  logic              rst_n,
   input  drail_t [N_IN-1:0] x_i,
   output drail_t            s_o,
   output drail_t            c_o
);

   localparam int unsigned NM = 1 << N_IN;

   if (N_IN < 2 || N_IN > 3) begin : g_bad_n
      $error("drm_adder: N_IN must be 2 or 3");
   end

   logic [NM-1:0] mt, s1, s0, c1, c0;

   for (genvar m = 0; m < NM; m++) begin : g_mt
      localparam int unsigned PC = pop_cnt(m);
      logic [N_IN-1:0] sel;
      for (genvar k = 0; k < N_IN; k++) begin : g_sel
         localparam bit HI = ((m >> k) & 1) != 0;
         assign sel[k] = HI ? x_i[k].one : x_i[k].zero;
      end
      drm_celem #(.N_IN(N_IN), .RST_VAL(1'b0)) u_c (
         .rst_n (rst_n),
         .in_i  (sel),
         .q_o   (mt[m])
      );
      assign s1[m] = (PC % 2 == 1) ? mt[m] : 1'b0;
      assign s0[m] = (PC % 2 == 1) ? 1'b0  : mt[m];
      assign c1[m] = (PC >= 2)     ? mt[m] : 1'b0;
      assign c0[m] = (PC >= 2)     ? 1'b0  : mt[m];
   end

   logic sum1, sum0, cy1, cy0;
   assign sum1 = |s1;
   assign sum0 = |s0;
   assign cy1  = |c1;
   assign cy0  = |c0;
   assign s_o  = '{one: sum1, zero: sum0};
   assign c_o  = '{one: cy1, zero: cy0};

   logic all_valid;
   always_comb begin
      all_valid = 1'b1;
      for (int k = 0; k < N_IN; k++)
         all_valid &= x_i[k].one ^ x_i[k].zero;
   end

   // R7
   always @(posedge sum1 or posedge sum0 or posedge cy1 or posedge cy0)
      if (rst_n === 1'b1)
         adder_fire_chk: assert (all_valid);

endmodule

// File: rtl/drm_cdet.sv
module drm_cdet #(
   parameter int unsigned NBITS = 8,
   parameter bit          RTO   = 1'b0
) (
   input  logic             rst_n,
   input  logic [NBITS-1:0] one_i,
   input  logic [NBITS-1:0] zero_i,
   output logic             ack_o
);

   localparam int unsigned NPAIR = (NBITS + 1) / 2;

   if (NBITS < 2) begin : g_bad_n
      $error("drm_cdet: NBITS must be at least 2");
   end

   logic [NBITS-1:0] bit_st;
   if (RTO) begin : g_and
      assign bit_st = one_i & zero_i;   // 1 = spacer
   end else begin : g_or
      assign bit_st = one_i | zero_i;   // 1 = valid
   end

   logic [NPAIR-1:0] lvl;
   for (genvar p = 0; p < NPAIR; p++) begin : g_leaf
      if (2 * p + 1 < NBITS) begin : g_two
         drm_celem #(.N_IN(2), .RST_VAL(RTO)) u_c (
            .rst_n (rst_n),
            .in_i  ({bit_st[2*p+1], bit_st[2*p]}),
            .q_o   (lvl[p])
         );
      end else begin : g_one
         drm_celem #(.N_IN(1), .RST_VAL(RTO)) u_c (
            .rst_n (rst_n),
            .in_i  (bit_st[2*p]),
            .q_o   (lvl[p])
         );
      end
   end

   logic root_q;
   drm_celem #(.N_IN(NPAIR), .RST_VAL(RTO)) u_root (
      .rst_n (rst_n),
      .in_i  (lvl),
      .q_o   (root_q)
   );

   assign ack_o = RTO ? ~root_q : root_q;

   // R5
   always @(posedge ack_o)
      if (rst_n === 1'b1)
         ack_rise_chk: assert ((one_i ^ zero_i) == {NBITS{1'b1}});

   // R6
   always @(negedge ack_o)
      if (rst_n === 1'b1)
         ack_fall_chk: assert (RTO ? ((one_i & zero_i) == {NBITS{1'b1}})
                                   : ((one_i | zero_i) == '0));

endmodule

// File: rtl/dr_array_mult.sv
module dr_array_mult
   import drm_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter bit          RTO   = 1'b0
) (
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   a_one,
   input  logic [WIDTH-1:0]   a_zero,
   input  logic [WIDTH-1:0]   b_one,
   input  logic [WIDTH-1:0]   b_zero,
   output logic [2*WIDTH-1:0] p_one,
   output logic [2*WIDTH-1:0] p_zero,
   output logic               ack
);

   localparam int unsigned PW    = 2 * WIDTH;
   localparam int unsigned NROWS = WIDTH - 1;

   // R10
   if (WIDTH < 2) begin : g_bad_w
      $error("dr_array_mult: WIDTH must be at least 2");
   end

   // ---- protocol front end: fold both protocols onto all-low spacer ----
   drail_t [WIDTH-1:0] ai, bi;
   for (genvar k = 0; k < WIDTH; k++) begin : g_in
      assign ai[k].one  = RTO ? ~a_one[k]  : a_one[k];
      assign ai[k].zero = RTO ? ~a_zero[k] : a_zero[k];
      assign bi[k].one  = RTO ? ~b_one[k]  : b_one[k];
      assign bi[k].zero = RTO ? ~b_zero[k] : b_zero[k];
   end

   // ---- partial products: pp[i][j] = a[j] & b[i] ----
   drail_t [WIDTH-1:0][WIDTH-1:0] pp;
   for (genvar i = 0; i < WIDTH; i++) begin : g_ppr
      for (genvar j = 0; j < WIDTH; j++) begin : g_ppc
         drm_and2 u_and (
            .rst_n (rst_n),
            .a_i   (ai[j]),
            .b_i   (bi[i]),
            .y_o   (pp[i][j])
         );
      end
   end

   // ---- ripple adder rows: row r adds pp[r+1] to the running sum ----
   drail_t [NROWS-1:0][WIDTH-1:0] sm, cy;
   for (genvar r = 0; r < NROWS; r++) begin : g_row
      for (genvar j = 0; j < WIDTH; j++) begin : g_cell
         localparam bit          HAS_B = !(r == 0 && j == WIDTH - 1);
         localparam bit          HAS_C = (j > 0);
         localparam int unsigned NI    = 1 + int'(HAS_B) + int'(HAS_C);
         drail_t [NI-1:0] ops;
         assign ops[0] = pp[r+1][j];
         if (r == 0 && j < WIDTH - 1) begin : g_b_pp
            assign ops[1] = pp[0][j+1];
         end else if (r > 0 && j < WIDTH - 1) begin : g_b_sum
            assign ops[1] = sm[r-1][j+1];
         end else if (r > 0) begin : g_b_cy
            assign ops[1] = cy[r-1][WIDTH-1];
         end
         if (HAS_C) begin : g_c
            assign ops[NI-1] = cy[r][j-1];
         end
         drm_adder #(.N_IN(NI)) u_add (
            .rst_n (rst_n),
            .x_i   (ops),
            .s_o   (sm[r][j]),
            .c_o   (cy[r][j])
         );
      end
   end

   // ---- product assembly ----
   drail_t [PW-1:0] pc;
   assign pc[0] = pp[0][0];
   for (genvar r = 0; r < NROWS; r++) begin : g_low
      assign pc[r+1] = sm[r][0];
   end
   for (genvar k = 0; k < WIDTH - 1; k++) begin : g_high
      assign pc[WIDTH+k] = sm[NROWS-1][k+1];
   end
   assign pc[PW-1] = cy[NROWS-1][WIDTH-1];

   for (genvar k = 0; k < PW; k++) begin : g_out
      assign p_one[k]  = RTO ? ~pc[k].one  : pc[k].one;
      assign p_zero[k] = RTO ? ~pc[k].zero : pc[k].zero;
   end

   // ---- completion detection on the external rails ----
   drm_cdet #(.NBITS(PW), .RTO(RTO)) u_cdet (
      .rst_n  (rst_n),
      .one_i  (p_one),
      .zero_i (p_zero),
      .ack_o  (ack)
   );

   // R4
   always_comb begin
      if (rst_n === 1'b1) begin
         for (int k = 0; k < PW; k++) begin
            legal_code_chk: assert (RTO ? (p_one[k] | p_zero[k]) : !(p_one[k] & p_zero[k]));
         end
      end
   end

endmodule

// File: tb/dr_array_mult_test.sv
module dr_array_mult_test;

   localparam int W  = 4;
   localparam int PW = 2 * W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic [W-1:0]  az1, az0, bz1, bz0, ao1, ao0, bo1, bo0;
   logic [PW-1:0] pz1, pz0, po1, po0;
   logic          ack_z, ack_o;

   dr_array_mult #(.WIDTH(W), .RTO(1'b0)) uut (
      .rst_n(rst_n), .a_one(az1), .a_zero(az0), .b_one(bz1), .b_zero(bz0),
      .p_one(pz1), .p_zero(pz0), .ack(ack_z));

   dr_array_mult #(.WIDTH(W), .RTO(1'b1)) uut_rto (
      .rst_n(rst_n), .a_one(ao1), .a_zero(ao0), .b_one(bo1), .b_zero(bo0),
      .p_one(po1), .p_zero(po0), .ack(ack_o));

   int n_chk = 0;
   int n_fail = 0;
   logic [PW-1:0] q_z[$];
   logic [PW-1:0] q_o[$];

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // R2 / R3 encodings
   task automatic drive_a(input logic [W-1:0] v, input bit valid);
      az1 = valid ? v  : '0;  az0 = valid ? ~v : '0;
      ao1 = valid ? ~v : '1;  ao0 = valid ? v  : '1;
   endtask

   task automatic drive_b(input logic [W-1:0] v, input bit valid);
      bz1 = valid ? v  : '0;  bz0 = valid ? ~v : '0;
      bo1 = valid ? ~v : '1;  bo0 = valid ? v  : '1;
   endtask

   task automatic push(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [PW-1:0] e;
      e = PW'(a) * PW'(b);
      q_z.push_back(e);
      q_o.push_back(e);
   endtask

   task automatic check_spacer(input string req);
      chk((pz1 | pz0) == '0, req, {pz1, pz0}, 16'h0000);
      chk((po1 & po0) == '1, req, {po1, po0}, 16'hffff);
   endtask

   // one full data/spacer handshake on both instances
   task automatic cycle(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      push(a, b);
      drive_a(a, 1'b1);
      drive_b(b, 1'b1);
      wait (ack_z && ack_o);
      @(negedge clk);
      drive_a('0, 1'b0);
      drive_b('0, 1'b0);
      wait (!ack_z && !ack_o);
      #1;
      check_spacer("R6 spacer after ack fall");
   endtask

   // monitor, return-to-zero instance: R1, R2, R4, R5
   initial begin : mon_z
      logic [PW-1:0] e;
      forever begin
         @(posedge ack_z);
         #2;
         if (q_z.size() == 0) chk(1'b0, "R5 RTZ ack with nothing pending", 16'(pz1), 16'h0);
         else begin
            e = q_z.pop_front();
            chk((pz1 ^ pz0) == '1, "R5 RTZ all bits valid", {pz1, pz0}, {e, ~e});
            chk(!(|(pz1 & pz0)), "R4 RTZ legal codes", {pz1, pz0}, {e, ~e});
            chk(pz1 == e && pz0 == ~e, "R1 R2 RTZ product", {pz1, pz0}, {e, ~e});
         end
      end
   end

   // monitor, return-to-one instance: R1, R3, R4, R5, R10
   initial begin : mon_o
      logic [PW-1:0] e;
      forever begin
         @(posedge ack_o);
         #2;
         if (q_o.size() == 0) chk(1'b0, "R5 RTO ack with nothing pending", 16'(po0), 16'h0);
         else begin
            e = q_o.pop_front();
            chk((po1 ^ po0) == '1, "R5 RTO all bits valid", {po1, po0}, {~e, e});
            chk((po1 | po0) == '1, "R4 RTO legal codes", {po1, po0}, {~e, e});
            chk(po0 == e && po1 == ~e, "R1 R3 R10 RTO product", {po1, po0}, {~e, e});
         end
      end
   end

   // watchdog
   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin : main
      rst_n = 1'b0;
      drive_a('0, 1'b0);
      drive_b('0, 1'b0);
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(!ack_z && !ack_o, "R9 ack low in reset", {14'h0, ack_z, ack_o}, 16'h0);
      check_spacer("R9 spacer in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R7: one operand valid, other spacer
      drive_a(4'd5, 1'b1);
      repeat (3) @(negedge clk);
      chk(!ack_z && !ack_o, "R7 ack stays low", {14'h0, ack_z, ack_o}, 16'h0);
      check_spacer("R7 product stays spacer");
      push(4'd5, 4'd9);
      drive_b(4'd9, 1'b1);
      wait (ack_z && ack_o);

      // R8: withdraw only operand A
      @(negedge clk);
      drive_a('0, 1'b0);
      repeat (3) @(negedge clk);
      chk(ack_z && ack_o, "R8 ack held", {14'h0, ack_z, ack_o}, 16'h3);
      chk(pz1 == 8'd45 && pz0 == ~8'd45, "R8 RTZ product held", {pz1, pz0}, {8'd45, ~8'd45});
      chk(po0 == 8'd45 && po1 == ~8'd45, "R8 RTO product held", {po1, po0}, {~8'd45, 8'd45});
      drive_b('0, 1'b0);
      wait (!ack_z && !ack_o);
      #1;
      check_spacer("R6 spacer after partial release");

      // R1 exhaustive over all operand pairs, both protocols
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            cycle(W'(a), W'(b));

      repeat (4) @(negedge clk);
      chk(q_z.size() == 0 && q_o.size() == 0, "R1 scoreboard drained",
          16'(q_z.size() + q_o.size()), 16'h0);
      report();
      $finish;
   end

endmodule